// File: doc/BRIEF.md
# Capacity Reservation Limit Engine

This block is the operation engine of a capacity controller that exposes several QoS register interfaces. One interface index is the machine-mode interface. A request carries the issuing interface, an operation code, a target interface identifier and a capacity block mask. The engine evaluates the request, holds busy for a fixed number of cycles and then posts a status code.

For the limit operation (op code 4), issued on the machine-mode interface with a valid target and a mask that is one contiguous run of ones, the engine sets the target interface's advertised count of allocatable capacity blocks to the number of ones in the mask. Every other operation code is only acknowledged.

Each interface's advertised block count is presented on a flat output bus, `CNT_W` bits per interface, with interface 0 in the lowest bits. The rest of the controller reads that bus.

Top module: `cap_limit_engine`

## Requirements
- R1: After reset, busy_o is 0, status_o is 0 (idle), and every interface advertises NBLK blocks.
- R2: Op code 4 issued from any interface other than MQRI_ID completes with status 2 and changes no block count. This holds even when the mask or target is also invalid.
- R3: Op code 4 issued from MQRI_ID, with a target below NUM_QRI and a nonzero contiguous mask, completes with status 1. The target's count becomes the number of ones in the mask, and the other counts are unchanged.
- R4: Op code 4 from MQRI_ID whose mask has more than one run of ones completes with status 5 and changes no count.
- R5: Op code 4 from MQRI_ID with an all-zero mask completes with status 5 and changes no count.
- R6: Op code 4 from MQRI_ID with a target of NUM_QRI or above completes with status 5 and changes no count.
- R7: Any op code other than 4 completes with status 1 and changes no count, whatever the target field and mask hold.
- R8: A request is accepted on a clock edge where req_valid_i is 1 and busy_o is 0. busy_o is then 1 for exactly OP_LAT cycles. status_o and the counts take the result on the edge where busy_o returns to 0, and status_o holds between results.
- R9: A request presented while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_src_i | input | QW | Index of the interface issuing the request |
| req_op_i | input | 5 | Operation code |
| req_qrid_i | input | 4 | Target interface field |
| req_mask_i | input | NBLK | Capacity block mask |
| busy_o | output | 1 | Operation in progress |
| status_o | output | 4 | Last completion status: 0 idle, 1 ok, 2 denied, 5 bad argument |
| ncblks_o | output | NUM_QRI*CNT_W | Advertised block count per interface |

## Verification
The bench builds the engine with NUM_QRI=3, NBLK=16, MQRI_ID=0 and OP_LAT=3. With only three interfaces, the 4-bit target field can carry values 3 and 15, which exercise the out-of-range rejection. The 16-bit mask lets the bench reach full-width runs, runs touching the top bit, single bits and split runs. An OP_LAT of 3 leaves room to present a second request inside the busy window.

// File: rtl/cap_limit_pkg.sv
package cap_limit_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_OK      = 4'd1,
    ST_DENIED  = 4'd2,
    ST_BAD_ARG = 4'd5
  } status_e;

  localparam logic [4:0] OP_QRI_LIMIT = 5'd4;
endpackage

// File: rtl/cap_mask_eval.sv
module cap_mask_eval #(
  parameter int NBLK  = 16,
  parameter int CNT_W = $clog2(NBLK + 1)
) (
  input  logic [NBLK-1:0]  mask_i,
  output logic             ok_o,
  output logic [CNT_W-1:0] ones_o
);
  logic [NBLK-1:0] lsb, sum;

  // Adding the lowest set bit clears the lowest run; leftover overlap means a second run.
  always_comb begin
    lsb  = mask_i & (~mask_i + 1'b1);
    sum  = mask_i + lsb;
    ok_o = (|mask_i) && ((mask_i & sum) == '0);
  end

  always_comb begin
    ones_o = '0;
    for (int i = 0; i < NBLK; i++) ones_o = ones_o + CNT_W'(mask_i[i]);
  end
endmodule

// File: rtl/cap_req_check.sv
module cap_req_check
  import cap_limit_pkg::*;
#(
  parameter int NUM_QRI = 4,
  parameter int QW      = 2,
  parameter int MQRI_ID = 0
) (
  input  logic          is_limit_i,
  input  logic [QW-1:0] src_i,
  input  logic [3:0]    tgt_i,
  input  logic          mask_ok_i,
  output status_e       status_o
);
  always_comb begin
    if (!is_limit_i)                                status_o = ST_OK;
    else if (src_i != QW'(MQRI_ID))                 status_o = ST_DENIED;
    else if (int'(tgt_i) >= NUM_QRI || !mask_ok_i)  status_o = ST_BAD_ARG;
    else                                            status_o = ST_OK;
  end
endmodule

// File: rtl/cap_ncblks_bank.sv
module cap_ncblks_bank #(
  parameter int NUM_QRI = 4,
  parameter int NBLK    = 16,
  parameter int CNT_W   = $clog2(NBLK + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [3:0]               wr_idx_i,
  input  logic [CNT_W-1:0]         wr_val_i,
  output logic [NUM_QRI*CNT_W-1:0] ncblks_o
);
  for (genvar g = 0; g < NUM_QRI; g++) begin : g_ent
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q <= CNT_W'(NBLK);
      else if (wr_en_i && wr_idx_i == 4'(g))    cnt_q <= wr_val_i;
    end

    assign ncblks_o[g*CNT_W +: CNT_W] = cnt_q;

    assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q <= CNT_W'(NBLK)) && (cnt_q != '0));
  end
endmodule

// File: rtl/cap_limit_engine.sv
module cap_limit_engine
  import cap_limit_pkg::*;
#(
  parameter int NUM_QRI = 4,
  parameter int NBLK    = 16,
  parameter int MQRI_ID = 0,
  parameter int OP_LAT  = 3,
  parameter int QW      = (NUM_QRI > 1) ? $clog2(NUM_QRI) : 1,
  parameter int CNT_W   = $clog2(NBLK + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [QW-1:0]            req_src_i,
  input  logic [4:0]               req_op_i,
  input  logic [3:0]               req_qrid_i,
  input  logic [NBLK-1:0]          req_mask_i,
  output logic                     busy_o,
  output logic [3:0]               status_o,
  output logic [NUM_QRI*CNT_W-1:0] ncblks_o
);
  localparam int LW = $clog2(OP_LAT + 1);

  logic             mask_ok;
  logic [CNT_W-1:0] ones;
  status_e          chk_status;
  logic             is_limit, accept, commit;

  logic [LW-1:0]    cnt_q;
  status_e          pend_status_q, status_q;
  logic             pend_wr_q, pend_lim_q;
  logic [QW-1:0]    pend_src_q;
  logic [3:0]       pend_tgt_q;
  logic [CNT_W-1:0] pend_ones_q;

  assign is_limit = (req_op_i == OP_QRI_LIMIT);
  assign busy_o   = (cnt_q != '0);
  assign accept   = req_valid_i && !busy_o;
  assign commit   = (cnt_q == LW'(1));
  assign status_o = status_q;

  cap_mask_eval #(.NBLK(NBLK), .CNT_W(CNT_W)) u_mask (
    .mask_i (req_mask_i),
    .ok_o   (mask_ok),
    .ones_o (ones)
  );

  cap_req_check #(.NUM_QRI(NUM_QRI), .QW(QW), .MQRI_ID(MQRI_ID)) u_chk (
    .is_limit_i (is_limit),
    .src_i      (req_src_i),
    .tgt_i      (req_qrid_i),
    .mask_ok_i  (mask_ok),
    .status_o   (chk_status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      status_q      <= ST_IDLE;
      pend_status_q <= ST_IDLE;
      pend_wr_q     <= 1'b0;
      pend_lim_q    <= 1'b0;
      pend_src_q    <= '0;
      pend_tgt_q    <= '0;
      pend_ones_q   <= '0;
    end else if (accept) begin
      cnt_q         <= LW'(OP_LAT);
      pend_status_q <= chk_status;
      pend_wr_q     <= is_limit && (chk_status == ST_OK);
      pend_lim_q    <= is_limit;
      pend_src_q    <= req_src_i;
      pend_tgt_q    <= req_qrid_i;
      pend_ones_q   <= ones;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
      if (commit) status_q <= pend_status_q;
    end
  end

  cap_ncblks_bank #(.NUM_QRI(NUM_QRI), .NBLK(NBLK), .CNT_W(CNT_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (commit && pend_wr_q),
    .wr_idx_i (pend_tgt_q),
    .wr_val_i (pend_ones_q),
    .ncblks_o (ncblks_o)
  );

  assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);

  assert_cnt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !commit) |=> ($stable(ncblks_o) && $stable(status_o)));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_valid_i) |=> ($stable(ncblks_o) && $stable(status_o) && !busy_o));

  assert_denied_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && pend_lim_q && pend_src_q != QW'(MQRI_ID))
      |-> (status_o == 4'd2 && $stable(ncblks_o)));

  assert_status_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o inside {4'd0, 4'd1, 4'd2, 4'd5});
endmodule

// File: tb/cap_limit_engine_bench.sv
`timescale 1ns/1ps
module cap_limit_engine_bench;
  localparam int NUM_QRI = 3;
  localparam int NBLK    = 16;
  localparam int MQRI_ID = 0;
  localparam int OP_LAT  = 3;
  localparam int QW      = 2;
  localparam int CNT_W   = $clog2(NBLK + 1);

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0;
  logic [QW-1:0] req_src_i = '0;
  logic [4:0] req_op_i = '0;
  logic [3:0] req_qrid_i = '0;
  logic [NBLK-1:0] req_mask_i = '0;
  logic busy_o;
  logic [3:0] status_o;
  logic [NUM_QRI*CNT_W-1:0] ncblks_o;

  int checks = 0, failures = 0, cycles = 0;

  int exp_nc[NUM_QRI];
  int exp_status, exp_cnt;
  int p_status, p_wr, p_tgt, p_ones;

  always #2.5 clk_i = ~clk_i;

  cap_limit_engine #(.NUM_QRI(NUM_QRI), .NBLK(NBLK), .MQRI_ID(MQRI_ID), .OP_LAT(OP_LAT))
  u_cap_limit_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_src_i(req_src_i),
    .req_op_i(req_op_i), .req_qrid_i(req_qrid_i), .req_mask_i(req_mask_i),
    .busy_o(busy_o), .status_o(status_o), .ncblks_o(ncblks_o)
  );

  function automatic int dut_nc(int i);
    return int'(ncblks_o[i*CNT_W +: CNT_W]);
  endfunction

  function automatic int count_ones(logic [NBLK-1:0] m);
    int n = 0;
    for (int i = 0; i < NBLK; i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic int count_runs(logic [NBLK-1:0] m);
    int r = 0;
    for (int i = 0; i < NBLK; i++) if (m[i] && (i == 0 || !m[i-1])) r++;
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: behavioural, advanced on each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_QRI; i++) exp_nc[i] = NBLK;
      exp_status = 0; exp_cnt = 0; p_wr = 0;
    end else if (exp_cnt == 0 && req_valid_i) begin
      exp_cnt = OP_LAT;
      p_tgt = int'(req_qrid_i);
      p_ones = count_ones(req_mask_i);
      p_wr = 0;
      if (req_op_i != 5'd4) p_status = 1;
      else if (int'(req_src_i) != MQRI_ID) p_status = 2;
      else if (p_tgt >= NUM_QRI || count_runs(req_mask_i) != 1) p_status = 5;
      else begin p_status = 1; p_wr = 1; end
    end else if (exp_cnt > 0) begin
      if (exp_cnt == 1) begin
        exp_status = p_status;
        if (p_wr != 0) exp_nc[p_tgt] = p_ones;
      end
      exp_cnt--;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk_i) if (rst_ni) begin
    cycles++;
    check("R8 busy", int'(busy_o), (exp_cnt != 0) ? 1 : 0);
    check("R8 status", int'(status_o), exp_status);
    for (int i = 0; i < NUM_QRI; i++) check("R3 ncblks", dut_nc(i), exp_nc[i]);
  end

  task automatic issue(int src, int op, int qrid, logic [NBLK-1:0] mask);
    @(negedge clk_i);
    req_valid_i = 1; req_src_i = QW'(src); req_op_i = 5'(op);
    req_qrid_i = 4'(qrid); req_mask_i = mask;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic run_op(string tag, int src, int op, int qrid, logic [NBLK-1:0] mask,
                        int exp_st, int idx, int exp_cnt_v);
    issue(src, op, qrid, mask);
    repeat (OP_LAT) @(negedge clk_i);
    #1;
    check(tag, int'(status_o), exp_st);
    check(tag, dut_nc(idx), exp_cnt_v);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 busy", int'(busy_o), 0);
    check("R1 status", int'(status_o), 0);
    for (int i = 0; i < NUM_QRI; i++) check("R1 ncblks", dut_nc(i), NBLK);
    rst_ni = 1;
    @(negedge clk_i);

    run_op("R3 mid run", 0, 4, 1, 16'h00F0, 1, 1, 4);
    run_op("R3 wide run", 0, 4, 2, 16'h7FFE, 1, 2, 14);
    run_op("R3 top bit", 0, 4, 0, 16'h8000, 1, 0, 1);
    run_op("R3 full", 0, 4, 0, 16'hFFFF, 1, 0, 16);
    run_op("R2 non-machine src", 1, 4, 2, 16'h000F, 2, 2, 14);
    run_op("R2 precedence", 2, 4, 7, 16'h0101, 2, 1, 4);
    run_op("R4 split mask", 0, 4, 1, 16'h0101, 5, 1, 4);
    run_op("R4 split low", 0, 4, 2, 16'h0005, 5, 2, 14);
    run_op("R5 zero mask", 0, 4, 1, 16'h0000, 5, 1, 4);
    run_op("R6 target 3", 0, 4, 3, 16'h0003, 5, 2, 14);
    run_op("R6 target 15", 0, 4, 15, 16'h0003, 5, 1, 4);
    run_op("R7 other op", 1, 1, 2, 16'h0001, 1, 2, 14);
    run_op("R7 other op mqri", 0, 7, 1, 16'h00FF, 1, 1, 4);

    // R8: busy window length
    @(negedge clk_i);
    req_valid_i = 1; req_src_i = 0; req_op_i = 5'd4; req_qrid_i = 4'd2; req_mask_i = 16'h0003;
    @(negedge clk_i);
    req_valid_i = 0;
    for (int k = 0; k < OP_LAT; k++) begin
      check("R8 busy high", int'(busy_o), 1);
      @(negedge clk_i);
    end
    check("R8 busy low", int'(busy_o), 0);
    check("R8 result", dut_nc(2), 2);

    // R9: request while busy dropped
    issue(0, 4, 1, 16'h0003);
    @(negedge clk_i);
    req_valid_i = 1; req_src_i = 0; req_op_i = 5'd4; req_qrid_i = 4'd1; req_mask_i = 16'h00FF;
    @(negedge clk_i);
    req_valid_i = 0;
    repeat (OP_LAT) @(negedge clk_i);
    check("R9 first wins", dut_nc(1), 2);
    check("R9 still idle", int'(busy_o), 0);

    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule